// File: doc/BRIEF.md
# Floating-Point Status and Compare Unit

This block holds the floating-point status word of a processor's FPU. When an arithmetic or conversion operation finishes, the datapath pulses a completion strobe and presents the five raw IEEE 754 exception flags. The unit records those flags as the current exceptions. It then checks them against a trap-enable field in the same word. If any enabled flag is present, it raises a one-cycle trap request and writes the IEEE-exception trap type. Otherwise it ORs the flags into an accrued-exception field.

Compare instructions feed a magnitude relation, the NaN class of the operands and a destination select. The unit turns these into a 2-bit condition code and writes it into one of up to four condition fields. Any invalid-operation flag raised by the compare goes through the same trap-or-accrue path. A load port replaces only the software-writable fields of the word. The rounding mode is always presented from the stored word.

Top module: `fp_status_unit`

## Requirements
- R1: A synchronous active-low reset clears the whole status word to zero. While reset is low, `trap_req` is 0 and `round_mode` is 0.
- R2: Raw flag bit 4 is invalid, bit 3 overflow, bit 2 underflow, bit 1 divide-by-zero and bit 0 inexact. An event carrying at least one flag replaces the current-exception field (bits 4:0) with those flags on the next edge. An event with no flags leaves the word unchanged.
- R3: `trap_req` is high in the same cycle as the event when the flags AND the trap-enable field (bits 27:23, same bit order as the flags) is nonzero. On the next edge the trap-type field (bits 16:14) becomes 3'b001 and the accrued field is left as it was.
- R4: For an event with flags and no trap, the accrued field (bits 9:5, same bit order) becomes its old value ORed with the flags.
- R5: A compare writes a code into the field picked by `cmp_sel`: 0 selects bits 11:10, 1 selects 33:32, 2 selects 35:34 and 3 selects 37:36. The codes are equal 00, less 01, greater 10 and unordered 11. The other condition fields are untouched.
- R6: A compare is unordered when either NaN input is set or `cmp_rel` is 11. An unordered compare that does not trap also sets accrued-invalid (bit 9).
- R7: A signaling compare raises invalid for any NaN operand. A quiet compare raises invalid only for a signaling NaN. That invalid flag goes through R2 to R4, and a compare that traps writes no condition field.
- R8: A load takes bits 37:32, 31:30, 27:23, 11:10, 9:5 and 4:0 from `ld_data` and keeps every other bit, including the trap type. `round_mode` always shows bits 31:30.
- R9: When a load falls in the same cycle as an event, the event's update is formed first and the load's masked bits then override it. The trap request and trap type still come from the event, judged against the trap-enable field held before the load.
- R10: When an operation completion and a compare fall in the same cycle, their flags are merged into one update, one trap decision and one accrual.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_done | input | 1 | Operation-complete strobe |
| op_flags | input | 5 | Raw IEEE flags of the finished operation |
| cmp_valid | input | 1 | Compare result strobe |
| cmp_signaling | input | 1 | 1 = signaling compare, 0 = quiet compare |
| cmp_sel | input | 2 | Destination condition field |
| cmp_rel | input | 2 | Magnitude relation (00 eq, 01 lt, 10 gt, 11 unordered) |
| cmp_qnan | input | 1 | An operand is a quiet NaN |
| cmp_snan | input | 1 | An operand is a signaling NaN |
| ld_valid | input | 1 | Status word load strobe |
| ld_data | input | 64 | Status word load value |
| fsr | output | 64 | Status word |
| trap_req | output | 1 | One-cycle floating-point exception trap request |
| round_mode | output | 2 | Rounding mode from the status word |

## Verification
The collision that matters is a load landing in the same cycle as an exception event. The trap decision must use the old enable field, while the load rewrites that field and the accrued and current fields under it. The bench provokes this by arming the invalid trap, then issuing a load that clears all enables, pulsed together with an invalid operation. It judges the result by `trap_req` in that cycle and by a word that carries the loaded fields alongside the event's trap type. A second collision, an operation completing together with a signaling compare, is checked by the merged current-exception value and the written condition field.

// File: rtl/fpsu_pkg.sv
package fpsu_pkg;

   localparam int EXC_W    = 5;
   localparam int EXC_NV   = 4;
   localparam int CEXC_LSB = 0;
   localparam int AEXC_LSB = 5;
   localparam int FCC0_LSB = 10;
   localparam int FTT_LSB  = 14;
   localparam int FTT_W    = 3;
   localparam int TEM_LSB  = 23;
   localparam int RM_LSB   = 30;
   localparam int RM_W     = 2;
   localparam int CC_W     = 2;

   localparam logic [FTT_W-1:0] FTT_IEEE = 3'd1;

   typedef enum logic [1:0] {
      REL_EQ = 2'b00,
      REL_LT = 2'b01,
      REL_GT = 2'b10,
      REL_UN = 2'b11
   } rel_e;

   // Condition field k sits at an offset of 0, 22, 24, 26 from field 0.
   function automatic int cc_lsb(input int k);
      return (k == 0) ? FCC0_LSB : FCC0_LSB + 20 + 2 * k;
   endfunction

endpackage

// File: rtl/fpsu_exc_ctl.sv
module fpsu_exc_ctl
   import fpsu_pkg::*;
(
   input  logic             evt,
   input  logic [EXC_W-1:0] flags,
   input  logic [EXC_W-1:0] tem,
   output logic             has_flags,
   output logic             trap
);

   always_comb begin
      has_flags = evt && (|flags);
      trap      = evt && (|(flags & tem));
   end

endmodule

// File: rtl/fpsu_cmp_eval.sv
module fpsu_cmp_eval
   import fpsu_pkg::*;
(
   input  logic       cmp_valid,
   input  logic       signaling,
   input  logic [1:0] rel_in,
   input  logic       qnan,
   input  logic       snan,
   output rel_e       code,
   output logic       inv
);

   logic unord;

   always_comb begin
      unord = qnan || snan || (rel_e'(rel_in) == REL_UN);
      code  = unord ? REL_UN : rel_e'(rel_in);
      inv   = cmp_valid && (snan || (signaling && qnan));
   end

endmodule

// File: rtl/fpsu_cc_merge.sv
module fpsu_cc_merge
   import fpsu_pkg::*;
#(
   parameter int NUM_CC = 4,
   localparam int SEL_W = (NUM_CC > 1) ? $clog2(NUM_CC) : 1
)(
   input  logic                   wr_en,
   input  logic [SEL_W-1:0]       sel,
   input  rel_e                   code,
   input  logic [CC_W*NUM_CC-1:0] cc_in,
   output logic [CC_W*NUM_CC-1:0] cc_out
);

   for (genvar k = 0; k < NUM_CC; k++) begin : g_field
      assign cc_out[CC_W*k +: CC_W] =
         (wr_en && (sel == SEL_W'(k))) ? code : cc_in[CC_W*k +: CC_W];
   end

endmodule

// File: rtl/fp_status_unit.sv
module fp_status_unit
   import fpsu_pkg::*;
#(
   parameter int REG_W  = 64,
   parameter int NUM_CC = 4,
   localparam int SEL_W = (NUM_CC > 1) ? $clog2(NUM_CC) : 1
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             op_done,
   input  logic [4:0]       op_flags,
   input  logic             cmp_valid,
   input  logic             cmp_signaling,
   input  logic [SEL_W-1:0] cmp_sel,
   input  logic [1:0]       cmp_rel,
   input  logic             cmp_qnan,
   input  logic             cmp_snan,
   input  logic             ld_valid,
   input  logic [REG_W-1:0] ld_data,
   output logic [REG_W-1:0] fsr,
   output logic             trap_req,
   output logic [1:0]       round_mode
);

   localparam int TOP_CC = cc_lsb(NUM_CC - 1) + CC_W;
   localparam int MIN_W  = (TOP_CC > 32) ? TOP_CC : 32;

   if (!(NUM_CC == 1 || NUM_CC == 4)) begin : g_bad_num_cc
      $error("fp_status_unit: NUM_CC must be 1 or 4");
   end
   if (REG_W < MIN_W) begin : g_bad_reg_w
      $error("fp_status_unit: REG_W too small for the field layout");
   end

   function automatic logic [REG_W-1:0] mk_ld_mask();
      logic [REG_W-1:0] m;
      m = '0;
      m[CEXC_LSB +: EXC_W] = '1;
      m[AEXC_LSB +: EXC_W] = '1;
      m[TEM_LSB  +: EXC_W] = '1;
      m[RM_LSB   +: RM_W]  = '1;
      for (int k = 0; k < NUM_CC; k++) m[cc_lsb(k) +: CC_W] = '1;
      return m;
   endfunction

   localparam logic [REG_W-1:0] LD_MASK = mk_ld_mask();

   logic [REG_W-1:0]       fsr_q, fsr_d;
   logic [EXC_W-1:0]       flags;
   logic [EXC_W-1:0]       tem;
   logic                   evt, has_flags, trap;
   logic                   cmp_inv, cc_wr;
   rel_e                   cmp_code;
   logic [CC_W*NUM_CC-1:0] cc_cur, cc_new;

   assign tem   = fsr_q[TEM_LSB +: EXC_W];
   assign evt   = op_done || cmp_valid;
   assign flags = (op_done ? op_flags : '0) | {cmp_inv, {(EXC_W-1){1'b0}}};
   assign cc_wr = cmp_valid && !trap;

   fpsu_cmp_eval u_cmp (
      .cmp_valid (cmp_valid),
      .signaling (cmp_signaling),
      .rel_in    (cmp_rel),
      .qnan      (cmp_qnan),
      .snan      (cmp_snan),
      .code      (cmp_code),
      .inv       (cmp_inv)
   );

   fpsu_exc_ctl u_exc (
      .evt       (evt),
      .flags     (flags),
      .tem       (tem),
      .has_flags (has_flags),
      .trap      (trap)
   );

   for (genvar k = 0; k < NUM_CC; k++) begin : g_cc_tap
      assign cc_cur[CC_W*k +: CC_W] = fsr_q[cc_lsb(k) +: CC_W];
   end

   fpsu_cc_merge #(.NUM_CC(NUM_CC)) u_cc (
      .wr_en  (cc_wr),
      .sel    (cmp_sel),
      .code   (cmp_code),
      .cc_in  (cc_cur),
      .cc_out (cc_new)
   );

   always_comb begin
      fsr_d = fsr_q;
      if (has_flags) begin
         fsr_d[CEXC_LSB +: EXC_W] = flags;
         if (trap) fsr_d[FTT_LSB +: FTT_W] = FTT_IEEE;
         else      fsr_d[AEXC_LSB +: EXC_W] = fsr_q[AEXC_LSB +: EXC_W] | flags;
      end
      if (cc_wr) begin
         for (int k = 0; k < NUM_CC; k++)
            fsr_d[cc_lsb(k) +: CC_W] = cc_new[CC_W*k +: CC_W];
         if (cmp_code == REL_UN) fsr_d[AEXC_LSB + EXC_NV] = 1'b1;
      end
      if (ld_valid) fsr_d = (ld_data & LD_MASK) | (fsr_d & ~LD_MASK);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) fsr_q <= '0;
      else        fsr_q <= fsr_d;
   end

   assign fsr        = fsr_q;
   assign trap_req   = trap;
   assign round_mode = fsr_q[RM_LSB +: RM_W];

   // R1
   p_reset_clear_r1: assert property (@(posedge clk)
      !rst_n |=> (fsr == '0));

   // R2
   p_cexc_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (has_flags && !ld_valid) |=> (fsr[CEXC_LSB +: EXC_W] == $past(flags)));

   // R2
   p_quiet_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!has_flags && !cmp_valid && !ld_valid) |=> (fsr == $past(fsr)));

   // R3
   p_trap_type_r3: assert property (@(posedge clk) disable iff (!rst_n)
      trap_req |=> (fsr[FTT_LSB +: FTT_W] == FTT_IEEE));

   // R3
   p_trap_no_accrue_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (trap_req && !ld_valid) |=> (fsr[AEXC_LSB +: EXC_W] == $past(fsr[AEXC_LSB +: EXC_W])));

   // R3
   p_trap_needs_event_r3: assert property (@(posedge clk) disable iff (!rst_n)
      trap_req |-> (op_done || cmp_valid));

   // R4
   p_accrue_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (has_flags && !trap_req && !ld_valid) |=>
         ((fsr[AEXC_LSB +: EXC_W] & $past(flags)) == $past(flags)));

   // R6
   p_unord_nv_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (cmp_valid && !trap_req && !ld_valid && (cmp_qnan || cmp_snan)) |=>
         fsr[AEXC_LSB + EXC_NV]);

endmodule

// File: tb/fp_status_unit_tb_top.sv
`timescale 1ns/1ps
module fp_status_unit_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        op_done = 1'b0;
   logic [4:0]  op_flags = '0;
   logic        cmp_valid = 1'b0;
   logic        cmp_signaling = 1'b0;
   logic [1:0]  cmp_sel = '0;
   logic [1:0]  cmp_rel = '0;
   logic        cmp_qnan = 1'b0;
   logic        cmp_snan = 1'b0;
   logic        ld_valid = 1'b0;
   logic [63:0] ld_data = '0;
   logic [63:0] fsr;
   logic        trap_req;
   logic [1:0]  round_mode;

   int   n_chk = 0;
   int   n_bad = 0;
   logic got_trap;
   bit   finished = 0;

   always #5 clk = ~clk;

   fp_status_unit dut_i (
      .clk(clk), .rst_n(rst_n), .op_done(op_done), .op_flags(op_flags),
      .cmp_valid(cmp_valid), .cmp_signaling(cmp_signaling), .cmp_sel(cmp_sel),
      .cmp_rel(cmp_rel), .cmp_qnan(cmp_qnan), .cmp_snan(cmp_snan),
      .ld_valid(ld_valid), .ld_data(ld_data), .fsr(fsr),
      .trap_req(trap_req), .round_mode(round_mode)
   );

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // Drive one cycle of stimulus; capture trap_req before the edge.
   task automatic step(input logic op, input logic [4:0] fl,
                       input logic cv, input logic sig, input logic [1:0] sel,
                       input logic [1:0] rel, input logic qn, input logic sn,
                       input logic lv, input logic [63:0] ld);
      @(negedge clk);
      op_done = op; op_flags = fl; cmp_valid = cv; cmp_signaling = sig;
      cmp_sel = sel; cmp_rel = rel; cmp_qnan = qn; cmp_snan = sn;
      ld_valid = lv; ld_data = ld;
      #1 got_trap = trap_req;
      @(posedge clk); #1;
      op_done = 0; op_flags = '0; cmp_valid = 0; cmp_signaling = 0;
      cmp_sel = '0; cmp_rel = '0; cmp_qnan = 0; cmp_snan = 0;
      ld_valid = 0; ld_data = '0;
   endtask

   task automatic t_reset;
      rst_n = 0;
      repeat (3) @(posedge clk);
      #1;
      chk("R1 word", fsr, 64'h0);
      chk("R1 trap", {63'h0, trap_req}, 64'h0);
      chk("R1 rm", {62'h0, round_mode}, 64'h0);
      @(negedge clk) rst_n = 1;
   endtask

   task automatic t_accrue;
      step(1, 5'b00001, 0, 0, 0, 0, 0, 0, 0, 0);
      chk("R4 trap inexact", {63'h0, got_trap}, 64'h0);
      chk("R2 R4 inexact", fsr, 64'h21);
      step(1, 5'b10010, 0, 0, 0, 0, 0, 0, 0, 0);
      chk("R2 R4 nv+dz", fsr, 64'h272);
      step(1, 5'b00000, 0, 0, 0, 0, 0, 0, 0, 0);
      chk("R2 no flags hold", fsr, 64'h272);
   endtask

   task automatic t_load;
      step(0, 0, 0, 0, 0, 0, 0, 0, 1, 64'h0000_0100_8401_C000);
      chk("R8 masked load", fsr, 64'h8400_0000);
      chk("R8 round mode", {62'h0, round_mode}, 64'h2);
   endtask

   task automatic t_trap;
      step(1, 5'b01000, 0, 0, 0, 0, 0, 0, 0, 0);
      chk("R3 trap_req", {63'h0, got_trap}, 64'h1);
      chk("R3 trap word", fsr, 64'h8400_4008);
      step(1, 5'b00001, 0, 0, 0, 0, 0, 0, 0, 0);
      chk("R4 masked flag", {63'h0, got_trap}, 64'h0);
      chk("R4 accrue after trap", fsr, 64'h8400_4021);
   endtask

   task automatic t_compare;
      step(0, 0, 1, 0, 2'd0, 2'b01, 0, 0, 0, 0);
      chk("R5 less sel0", fsr, 64'h0000_0000_8400_4421);
      step(0, 0, 1, 0, 2'd1, 2'b10, 0, 0, 0, 0);
      chk("R5 greater sel1", fsr, 64'h0000_0002_8400_4421);
      step(0, 0, 1, 0, 2'd2, 2'b00, 1, 0, 0, 0);
      chk("R6 R7 quiet qnan sel2", fsr, 64'h0000_000E_8400_4621);
      step(0, 0, 1, 1, 2'd3, 2'b00, 1, 0, 0, 0);
      chk("R7 signaling qnan trap", {63'h0, got_trap}, 64'h0);
      chk("R7 signaling qnan sel3", fsr, 64'h0000_003E_8400_4630);
      step(0, 0, 1, 0, 2'd0, 2'b00, 0, 0, 0, 0);
      chk("R5 equal sel0", fsr, 64'h0000_003E_8400_4230);
   endtask

   task automatic t_cmp_trap;
      step(0, 0, 0, 0, 0, 0, 0, 0, 1, 64'h0000_0000_4800_0000);
      chk("R8 reload keeps ftt", fsr, 64'h4800_4000);
      chk("R8 round mode 1", {62'h0, round_mode}, 64'h1);
      step(0, 0, 1, 0, 2'd1, 2'b01, 0, 1, 0, 0);
      chk("R7 quiet snan trap_req", {63'h0, got_trap}, 64'h1);
      chk("R7 trapped compare no write", fsr, 64'h4800_4010);
   endtask

   task automatic t_collide_load;
      step(1, 5'b10000, 0, 0, 0, 0, 0, 0, 1, 64'h0000_0000_0000_03E0);
      chk("R9 trap from old enables", {63'h0, got_trap}, 64'h1);
      chk("R9 load over event", fsr, 64'h0000_43E0);
   endtask

   task automatic t_collide_cmp;
      step(1, 5'b01000, 1, 1, 2'd2, 2'b00, 0, 1, 0, 0);
      chk("R10 merged no trap", {63'h0, got_trap}, 64'h0);
      chk("R10 merged word", fsr, 64'h0000_000C_0000_43F8);
      step(0, 0, 1, 0, 2'd0, 2'b11, 0, 0, 0, 0);
      chk("R6 rel 11 unordered", fsr, 64'h0000_000C_0000_4FF8);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual hung expected done");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      t_reset();
      t_accrue();
      t_load();
      t_trap();
      t_compare();
      t_cmp_trap();
      t_collide_load();
      t_collide_cmp();
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule